// File: doc/BRIEF.md
# Stereo Record-Path Polarity and DC-Block Stage

This block post-processes a stereo stream of recorded audio one sample pair at a time. Every clock in which the sample strobe is high, it accepts one signed 24-bit word per channel. It can flip the sign of that word, and it can remove the DC component with a first-order high-pass filter. Each of the two operations has its own static control bit. Results leave on a registered output whose valid flag trails the input strobe by exactly one cycle.

The filter uses one fixed feedback coefficient of 2^-12 per sample, so its corner sits at a fixed fraction of the sample rate. At 48 kHz that fraction gives about 1.9 Hz, and the corner moves in proportion when the sample rate changes. When both features are used, the sign flip happens first. All arithmetic clamps to the signed 24-bit range instead of wrapping. The two channels share the control bits, but each keeps its own filter history.

Top module: `rec_postproc`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and both output samples are 0; the filter history of both channels is zero.
- R2: With `inv_en`=0 and `hpf_en`=0, each output sample equals the input sample of the same channel taken with the previous strobe.
- R3: With `inv_en`=1 and `hpf_en`=0, each output sample is the two's-complement negation of its input sample.
- R4: Negating the most negative code (0x800000) yields the most positive code (0x7FFFFF), and 0 maps to 0.
- R5: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1. In cycles after `in_valid`=0 the output samples keep their previous values.
- R6: With `hpf_en`=1, each output is y[n] = x[n] - x[n-1] + y[n-1] - (y[n-1] >>> 12), where x is the post-inversion sample and the history starts at zero. The history advances only on strobed samples, which places the corner near 1.9 Hz at 48 kHz and scales it with the sample rate.
- R7: Filter results outside the signed 24-bit range clamp to 0x7FFFFF or 0x800000, and the clamped value becomes y[n-1] for the next sample.
- R8: When both bits are set, the inversion is applied before the filter, so the first filtered output after enabling is the negated input.
- R9: While `hpf_en` is 0, the filter history is held at zero, so the first output after re-enabling equals the first post-inversion input.
- R10: The left and right filter histories are independent: samples on one channel never change the other channel's output.
- R11: A constant input held at the filter for 30000 samples settles to an output whose magnitude is below 4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_en | input | 1 | 1: negate samples (static) |
| hpf_en | input | 1 | 1: enable DC-blocking filter (static); 0 also clears filter history |
| in_valid | input | 1 | Sample strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_left | output | 24 | Left processed sample, signed |
| out_right | output | 24 | Right processed sample, signed |

## Verification
A corrupt filter history shows up on the very next strobed output of that channel as a wrong difference term. Because of the 2^-12 leak, the error then decays only over thousands of samples, so a long DC run and exact sample-by-sample comparison catch even a one-LSB history fault. Clamping faults surface only on full-scale alternating input, where a wrapped accumulator flips the output sign in the same cycle. A history that is not cleared while the filter is disabled shows up in the first output after re-enable.

// File: rtl/rec_pkg.sv
package rec_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } rec_chan_e;

    typedef struct packed {
        logic invert;
        logic dc_block;
    } rec_ctrl_t;

    // Clamp a signed value to the signed range of w bits (w <= 63).
    function automatic logic signed [63:0] clamp_s(input logic signed [63:0] v,
                                                   input int unsigned w);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (w - 1));
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/rec_polarity.sv
module rec_polarity #(
    parameter int DATA_W = 24
) (
    input  logic                     flip,
    input  logic signed [DATA_W-1:0] x_in,
    output logic signed [DATA_W-1:0] x_out
);
    localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

    always_comb begin
        if (!flip)            x_out = x_in;
        else if (x_in == MIN_V) x_out = MAX_V;
        else                  x_out = -x_in;
    end
endmodule

// File: rtl/rec_dcblock.sv
module rec_dcblock #(
    parameter int DATA_W = 24,
    parameter int SHIFT  = 12,
    parameter int GUARD  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     enable,
    input  logic                     step,
    input  logic signed [DATA_W-1:0] x_in,
    output logic signed [DATA_W-1:0] y_out
);
    localparam int AW = DATA_W + GUARD;

    logic signed [DATA_W-1:0] x_hist_q;
    logic signed [DATA_W-1:0] y_hist_q;
    logic signed [AW-1:0]     acc;
    logic signed [63:0]       acc_wide;
    logic signed [63:0]       clamped;

    always_comb begin
        acc = AW'(x_in) - AW'(x_hist_q) + AW'(y_hist_q) - AW'(y_hist_q >>> SHIFT);
        acc_wide = 64'(acc);
        clamped  = rec_pkg::clamp_s(acc_wide, DATA_W);
        y_out    = clamped[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            x_hist_q <= '0;
            y_hist_q <= '0;
        end else if (step) begin
            x_hist_q <= x_in;
            y_hist_q <= y_out;
        end
    end
endmodule

// File: rtl/rec_channel.sv
module rec_channel
    import rec_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int SHIFT  = 12,
    parameter int GUARD  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  rec_ctrl_t                ctrl,
    input  logic                     step,
    input  logic signed [DATA_W-1:0] x_in,
    output logic signed [DATA_W-1:0] y_q
);
    logic signed [DATA_W-1:0] x_pol;
    logic signed [DATA_W-1:0] x_filt;
    logic signed [DATA_W-1:0] y_next;

    rec_polarity #(.DATA_W(DATA_W)) u_pol (
        .flip  (ctrl.invert),
        .x_in  (x_in),
        .x_out (x_pol)
    );

    rec_dcblock #(.DATA_W(DATA_W), .SHIFT(SHIFT), .GUARD(GUARD)) u_hpf (
        .clk    (clk),
        .rst    (rst),
        .enable (ctrl.dc_block),
        .step   (step),
        .x_in   (x_pol),
        .y_out  (x_filt)
    );

    always_comb y_next = ctrl.dc_block ? x_filt : x_pol;

    always_ff @(posedge clk) begin
        if (rst)       y_q <= '0;
        else if (step) y_q <= y_next;
    end
endmodule

// File: rtl/rec_postproc.sv
module rec_postproc
    import rec_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int SHIFT  = 12,
    parameter int GUARD  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     inv_en,
    input  logic                     hpf_en,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right
);
    rec_ctrl_t                ctrl;
    logic signed [DATA_W-1:0] ch_in  [NUM_CH];
    logic signed [DATA_W-1:0] ch_out [NUM_CH];

    always_comb begin
        ctrl.invert   = inv_en;
        ctrl.dc_block = hpf_en;
        ch_in[CH_LEFT]  = in_left;
        ch_in[CH_RIGHT] = in_right;
        out_left  = ch_out[CH_LEFT];
        out_right = ch_out[CH_RIGHT];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        rec_channel #(.DATA_W(DATA_W), .SHIFT(SHIFT), .GUARD(GUARD)) u_ch (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl),
            .step (in_valid),
            .x_in (ch_in[c]),
            .y_q  (ch_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end
endmodule

// File: rtl/rec_postproc_chk.sv
module rec_postproc_chk #(
    parameter int DATA_W = 24
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     inv_en,
    input logic                     hpf_en,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_left,
    input logic signed [DATA_W-1:0] in_right,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_left,
    input logic signed [DATA_W-1:0] out_right
);
    localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_left == '0 && out_right == '0));

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

    // R2
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !inv_en && !hpf_en) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

    // R3
    invert_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && inv_en && !hpf_en && in_left != MIN_V) |=> (out_left == -$past(in_left)));

    // R4
    invert_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && inv_en && !hpf_en && in_left == MIN_V) |=> (out_left == MAX_V));
endmodule

bind rec_postproc rec_postproc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .inv_en    (inv_en),
    .hpf_en    (hpf_en),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
);

// File: tb/tb_rec_postproc.sv
`timescale 1ns/1ps
module tb_rec_postproc;
    localparam int DW = 24;
    localparam longint MAXV = (64'sd1 <<< (DW - 1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (DW - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inv_en = 1'b0;
    logic hpf_en = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_left = '0;
    logic signed [DW-1:0] in_right = '0;
    logic out_valid;
    logic signed [DW-1:0] out_left;
    logic signed [DW-1:0] out_right;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint exp_l[$];
    longint exp_r[$];
    string  exp_tag[$];
    longint mx[2];
    longint my[2];
    longint last_l, last_r;

    always #2.5 clk = ~clk;

    rec_postproc dut (
        .clk(clk), .rst(rst), .inv_en(inv_en), .hpf_en(hpf_en),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic longint clampv(input longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic longint model(input int ch, input longint raw);
        longint x, y;
        x = inv_en ? ((raw == MINV) ? MAXV : -raw) : raw;
        if (!hpf_en) return x;
        y = clampv(x - mx[ch] + my[ch] - (my[ch] >>> 12));
        mx[ch] = x;
        my[ch] = y;
        return y;
    endfunction

    task automatic set_ctrl(input bit inv, input bit hpf);
        inv_en = inv;
        hpf_en = hpf;
        if (!hpf) begin
            mx[0] = 0; mx[1] = 0; my[0] = 0; my[1] = 0;
        end
    endtask

    // Driver: present one strobed pair and queue the expected result.
    task automatic send(input longint l, input longint r, input string tag);
        in_valid = 1'b1;
        in_left  = DW'(l);
        in_right = DW'(r);
        exp_l.push_back(model(0, l));
        exp_r.push_back(model(1, r));
        exp_tag.push_back(tag);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // Monitor: compare each produced pair with the queue head.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_l.size() == 0) begin
                check(1'b0, "R5 unexpected out_valid", 1, 0);
            end else begin
                longint el, er;
                string t;
                el = exp_l.pop_front();
                er = exp_r.pop_front();
                t  = exp_tag.pop_front();
                last_l = longint'(out_left);
                last_r = longint'(out_right);
                check(longint'(out_left) == el, {t, " left"}, longint'(out_left), el);
                check(longint'(out_right) == er, {t, " right"}, longint'(out_right), er);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        set_ctrl(1'b0, 1'b0);
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R1 after reset",
              longint'(out_left), 0);
        @(posedge clk); #1;

        // R2 pass-through, several patterns
        send(123, -456, "R2 bypass");
        send(MAXV, MINV, "R2 bypass");
        send(0, 1, "R2 bypass");
        idle(1);
        @(negedge clk);
        check(out_valid == 1'b0, "R5 idle valid", longint'(out_valid), 0);
        check(out_left == 24'sd0 && out_right == 24'sd1, "R5 hold", longint'(out_right), 1);
        @(posedge clk); #1;

        // R3 / R4 inversion
        set_ctrl(1'b1, 1'b0);
        send(1000, -77, "R3 invert");
        send(MINV, MAXV, "R4 invert min");
        send(0, MINV, "R4 invert zero");
        idle(2);
        check(last_l == 0 && last_r == MAXV, "R4 direct", last_r, MAXV);

        // R6 filter from zero history, R10 independence
        set_ctrl(1'b0, 1'b1);
        for (int i = 0; i < 40; i++) send(300000, 0, "R6/R10 filter");
        for (int i = 0; i < 20; i++) send(-50000 + i * 7000, 200000 - i * 333, "R6 ramp");
        idle(2);

        // R7 clamping on full-scale alternation
        set_ctrl(1'b0, 1'b0); idle(1);
        set_ctrl(1'b0, 1'b1);
        send(MAXV, MINV, "R7 first");
        send(MINV, MAXV, "R7 clamp");
        idle(1);
        check(last_l == MINV && last_r == MAXV, "R7 direct", last_l, MINV);
        @(posedge clk); #1;
        send(MAXV, MINV, "R7 clamp back");
        idle(2);
        check(last_l == MAXV && last_r == MINV, "R7 direct back", last_l, MAXV);

        // R8 inversion before filter
        set_ctrl(1'b1, 1'b0); idle(1);
        set_ctrl(1'b1, 1'b1);
        send(400000, -12345, "R8 order");
        idle(2);
        check(last_l == -400000 && last_r == 12345, "R8 direct", last_l, -400000);
        for (int i = 0; i < 10; i++) send(400000, -12345, "R8 run");

        // R9 clear on disable, restart from zero
        set_ctrl(1'b0, 1'b0);
        idle(3);
        set_ctrl(1'b0, 1'b1);
        send(500000, -500000, "R9 restart");
        idle(2);
        check(last_l == 500000 && last_r == -500000, "R9 direct", last_l, 500000);

        // R11 long DC run
        set_ctrl(1'b0, 1'b0); idle(1);
        set_ctrl(1'b0, 1'b1);
        for (int i = 0; i < 30000; i++) send(1000000, -1000000, "R11 dc");
        idle(2);
        check(last_l < 4096 && last_l > -4096, "R11 settle left", last_l, 0);
        check(last_r < 4096 && last_r > -4096, "R11 settle right", last_r, 0);

        check(exp_l.size() == 0, "R5 queue drained", exp_l.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule